// File: doc/BRIEF.md
# Debug Vector Trap Controller

This block decides when a processor core must take a debug exception because execution has reached an exception vector that a debugger asked to watch. Each of seven exception vectors has its own trap enable, so a vector can be trapped without spending an address-comparator breakpoint slot. The block also gathers the other debug causes of the core: instruction, data and software breakpoints, an external break and a trace-full event. When several of them arrive together it picks one by priority and reports the winner as a method-of-entry code. Data aborts that happen inside the special debug state are not taken. They are recorded in a sticky status bit instead.

A debugger (or firmware) loads the control word over a single write-enable port. The word holds a global enable, a halt-mode bit, seven trap bits and a sticky-clear strobe. The control word is reset only by the power-on reset `por_n`. It is not reset by the processor reset `core_rst_i`. Because of this, the reset-vector trap can be armed before or during a processor reset and still fires once that reset ends.

The controller is a five-state machine:

- **INRST**: the core is held in reset.
- **RSTTRAP**: a reset-vector trap is pending.
- **RUN**: normal watching of causes.
- **PEND**: a request has been issued and the core has not yet entered debug.
- **SDS**: the special debug state.

Its transitions are:

- **Any state → INRST** whenever `core_rst_i` is high.
- **INRST → RSTTRAP** on reset release when halt mode and the reset trap bit are both set.
- **INRST → RUN** on reset release otherwise.
- **RSTTRAP → PEND** when it fires, which happens once `sdbg_i` is low.
- **RUN → PEND** when any cause fires.
- **RUN → SDS** when `sdbg_i` goes high.
- **PEND → SDS** when `sdbg_i` goes high.
- **SDS → RUN** when `sdbg_i` goes low.

Top module: `dbg_vtrap_ctrl`

## Requirements
- R1: A control write (`cfg_we_i`=1) takes effect in the following cycle and is accepted while `core_rst_i` is high. Its fields are:
  - bit 0: global enable.
  - bit 1: halt mode.
  - bit 2+k: trap enable for vector k.
  - bit 9: sticky-clear strobe.

  The fields survive `core_rst_i` and are cleared only by `por_n`.
- R2: The vector addresses are fixed: 0x00 (k=0, reset), 0x04 (k=1), 0x08 (k=2), 0x0C (k=3), 0x10 (k=4), 0x18 (k=5) and 0x1C (k=6). While in RUN, a valid fetch of vector k (k=1..6) raises `dbg_req_o` in the next cycle with `moe_o`=101, but only when global enable, halt mode and trap bit k are all set. Otherwise no request follows.
- R3: A fetch at 0x00 during RUN, or at any address that is not a vector, never causes a vector-trap request.
- R4: If halt mode and trap bit 0 are set when `core_rst_i` falls, `dbg_req_o` pulses in the second cycle after the release with `moe_o`=000, whatever the global enable is. Without both bits, no request follows the release.
- R5: When causes coincide, one request is made and `moe_o` reports the highest-priority cause. In priority order the causes and their codes are:
  - vector trap: 101
  - instruction breakpoint (`ibrk_i`): 001
  - data breakpoint (`dbrk_i`): 010
  - software breakpoint (`swbrk_i`): 011
  - external break (`extbrk_i`): 100
  - trace full (`tbfull_i`): 110
- R6: `dbg_req_o` is high for exactly one cycle. After a request, no further request is made until `sdbg_i` has been high and then low again.
- R7: No request is made in the cycle after a cycle in which `sdbg_i` or `core_rst_i` was high.
- R8: `sticky_abort_o` is set in the cycle after `dabort_i` and `sdbg_i` are both high while halt mode is set. It stays set until a write with bit 9 = 1 clears it, and a set in the same cycle wins over the clear. A data abort outside the special debug state, or with halt mode clear, leaves it unchanged.
- R9: `moe_o` is 000 after power-on reset and holds its value between requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, clears everything |
| core_rst_i | input | 1 | Processor reset, active high, keeps the control word |
| cfg_we_i | input | 1 | Control word write enable |
| cfg_wdata_i | input | NVEC+3 | Control word write data |
| fetch_valid_i | input | 1 | Instruction fetch valid |
| fetch_addr_i | input | AW | Instruction fetch address |
| ibrk_i | input | 1 | Instruction breakpoint hit |
| dbrk_i | input | 1 | Data breakpoint hit |
| swbrk_i | input | 1 | Software breakpoint executed |
| extbrk_i | input | 1 | External debug break |
| tbfull_i | input | 1 | Trace buffer full break |
| dabort_i | input | 1 | Data abort detected |
| sdbg_i | input | 1 | Core is in special debug state |
| dbg_req_o | output | 1 | Debug exception request pulse |
| moe_o | output | 3 | Method-of-entry code of the latest request |
| sticky_abort_o | output | 1 | Sticky data-abort status |

## Verification
The bench builds the block with `AW`=8, so the fetch address space has only 256 values. Every address is probed under all four combinations of global enable and halt mode and under three trap masks. This covers every vector, every non-vector address and the reset vector outside reset. All 64 combinations of the six debug causes are swept against the priority order. The reset-trap, masking and sticky-bit sequences are then driven cycle by cycle.

// File: rtl/dvt_pkg.sv
package dvt_pkg;

    localparam int NVEC   = 7;
    localparam int NCAUSE = 6;

    typedef enum logic [2:0] {
        MOE_RESET  = 3'b000,
        MOE_IBRK   = 3'b001,
        MOE_DBRK   = 3'b010,
        MOE_SWBRK  = 3'b011,
        MOE_EXT    = 3'b100,
        MOE_VTRAP  = 3'b101,
        MOE_TBFULL = 3'b110
    } moe_e;

    typedef enum logic [2:0] {
        S_INRST,
        S_RSTTRAP,
        S_RUN,
        S_PEND,
        S_SDS
    } vt_state_e;

    // Byte offset of exception vector k; slot 0x14 is not a vector.
    function automatic int vec_offset(input int k);
        return (k < 5) ? 4 * k : 4 * (k + 1);
    endfunction

    // Code for cause index i, ordered from highest priority (0) downwards.
    function automatic moe_e cause_code(input logic [2:0] i);
        unique case (i)
            3'd0:    return MOE_VTRAP;
            3'd1:    return MOE_IBRK;
            3'd2:    return MOE_DBRK;
            3'd3:    return MOE_SWBRK;
            3'd4:    return MOE_EXT;
            default: return MOE_TBFULL;
        endcase
    endfunction

endpackage

// File: rtl/dvt_cfg_regs.sv
module dvt_cfg_regs #(
    parameter int NVEC = dvt_pkg::NVEC,
    localparam int CFG_W  = NVEC + 3,
    localparam int CLR_BIT = NVEC + 2
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    input  logic             sa_set,
    output logic             ge_q,
    output logic             hm_q,
    output logic [NVEC-1:0]  trap_q,
    output logic             sticky_q
);

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            ge_q   <= 1'b0;
            hm_q   <= 1'b0;
            trap_q <= '0;
        end else if (we) begin
            ge_q   <= wdata[0];
            hm_q   <= wdata[1];
            trap_q <= wdata[NVEC+1:2];
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)
            sticky_q <= 1'b0;
        else if (sa_set)
            sticky_q <= 1'b1;
        else if (we && wdata[CLR_BIT])
            sticky_q <= 1'b0;
    end

endmodule

// File: rtl/dvt_vec_match.sv
module dvt_vec_match #(
    parameter int AW   = 32,
    parameter int NVEC = dvt_pkg::NVEC
) (
    input  logic            fetch_valid,
    input  logic [AW-1:0]   fetch_addr,
    input  logic            ge,
    input  logic            hm,
    input  logic [NVEC-1:1] trap_en,
    output logic            hit
);

    logic [NVEC-1:1] hit_k;

    for (genvar k = 1; k < NVEC; k++) begin : g_vec
        localparam logic [AW-1:0] VADDR = AW'(dvt_pkg::vec_offset(k));
        assign hit_k[k] = fetch_valid && (fetch_addr == VADDR) && trap_en[k];
    end

    assign hit = ge && hm && (|hit_k);

endmodule

// File: rtl/dvt_prio.sv
module dvt_prio #(
    parameter int NC = dvt_pkg::NCAUSE
) (
    input  logic [NC-1:0]     cause,
    output logic              any,
    output dvt_pkg::moe_e     code
);

    logic [2:0] sel;

    always_comb begin
        sel = 3'd0;
        for (int i = NC - 1; i >= 0; i--) begin
            if (cause[i]) sel = 3'(i);
        end
    end

    assign any  = |cause;
    assign code = dvt_pkg::cause_code(sel);

endmodule

// File: rtl/dbg_vtrap_ctrl.sv
module dbg_vtrap_ctrl #(
    parameter int AW   = 32,
    parameter int NVEC = dvt_pkg::NVEC,
    localparam int CFG_W   = NVEC + 3,
    localparam int CLR_BIT = NVEC + 2
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             core_rst_i,
    input  logic             cfg_we_i,
    input  logic [CFG_W-1:0] cfg_wdata_i,
    input  logic             fetch_valid_i,
    input  logic [AW-1:0]    fetch_addr_i,
    input  logic             ibrk_i,
    input  logic             dbrk_i,
    input  logic             swbrk_i,
    input  logic             extbrk_i,
    input  logic             tbfull_i,
    input  logic             dabort_i,
    input  logic             sdbg_i,
    output logic             dbg_req_o,
    output logic [2:0]       moe_o,
    output logic             sticky_abort_o
);
    import dvt_pkg::*;

    logic            ge_q, hm_q, sticky_q;
    logic [NVEC-1:0] trap_q;
    logic            sa_set, sa_clr_wr;
    logic            vt_hit;
    logic            cause_any;
    moe_e            cause_moe;
    logic [NCAUSE-1:0] causes;

    vt_state_e st_q, st_d;
    logic      fire, fire_rst;
    logic      req_q;
    moe_e      moe_q;

    // Abort seen inside special debug state is recorded, never taken.
    assign sa_set    = dabort_i && sdbg_i && hm_q;
    assign sa_clr_wr = cfg_we_i && cfg_wdata_i[CLR_BIT];

    dvt_cfg_regs #(.NVEC(NVEC)) u_cfg (
        .clk      (clk),
        .por_n    (por_n),
        .we       (cfg_we_i),
        .wdata    (cfg_wdata_i),
        .sa_set   (sa_set),
        .ge_q     (ge_q),
        .hm_q     (hm_q),
        .trap_q   (trap_q),
        .sticky_q (sticky_q)
    );

    dvt_vec_match #(.AW(AW), .NVEC(NVEC)) u_match (
        .fetch_valid (fetch_valid_i),
        .fetch_addr  (fetch_addr_i),
        .ge          (ge_q),
        .hm          (hm_q),
        .trap_en     (trap_q[NVEC-1:1]),
        .hit         (vt_hit)
    );

    assign causes = {tbfull_i, extbrk_i, swbrk_i, dbrk_i, ibrk_i, vt_hit};

    dvt_prio #(.NC(NCAUSE)) u_prio (
        .cause (causes),
        .any   (cause_any),
        .code  (cause_moe)
    );

    // Next-state and fire decision.
    always_comb begin
        st_d     = st_q;
        fire     = 1'b0;
        fire_rst = 1'b0;
        unique case (st_q)
            S_INRST: begin
                if (!core_rst_i)
                    st_d = (hm_q && trap_q[0]) ? S_RSTTRAP : S_RUN;
            end
            S_RSTTRAP: begin
                if (!sdbg_i) begin
                    fire     = 1'b1;
                    fire_rst = 1'b1;
                    st_d     = S_PEND;
                end
            end
            S_RUN: begin
                if (sdbg_i) begin
                    st_d = S_SDS;
                end else if (cause_any) begin
                    fire = 1'b1;
                    st_d = S_PEND;
                end
            end
            S_PEND: begin
                if (sdbg_i) st_d = S_SDS;
            end
            S_SDS: begin
                if (!sdbg_i) st_d = S_RUN;
            end
            default: st_d = S_INRST;
        endcase
        if (core_rst_i) begin
            st_d     = S_INRST;
            fire     = 1'b0;
            fire_rst = 1'b0;
        end
    end

    // State register.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= S_INRST;
        else        st_q <= st_d;
    end

    // Output register.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            req_q <= 1'b0;
            moe_q <= MOE_RESET;
        end else begin
            req_q <= fire;
            if (fire) moe_q <= fire_rst ? MOE_RESET : cause_moe;
        end
    end

    assign dbg_req_o      = req_q;
    assign moe_o          = moe_q;
    assign sticky_abort_o = sticky_q;

endmodule

// File: rtl/dvt_checker.sv
module dvt_checker (
    input logic       clk,
    input logic       por_n,
    input logic       core_rst_i,
    input logic       sdbg_i,
    input logic       dabort_i,
    input logic       hm_q,
    input logic       ge_q,
    input logic       trap0_q,
    input logic       sa_clr_wr,
    input logic       dbg_req_o,
    input logic [2:0] moe_o,
    input logic       sticky_abort_o
);

    p_single_pulse_r6: assert property (@(posedge clk) disable iff (!por_n)
        dbg_req_o |=> !dbg_req_o);

    p_mask_sds_r7: assert property (@(posedge clk) disable iff (!por_n)
        $past(sdbg_i) |-> !dbg_req_o);

    p_mask_rst_r7: assert property (@(posedge clk) disable iff (!por_n)
        $past(core_rst_i) |-> !dbg_req_o);

    p_vtrap_gate_r2: assert property (@(posedge clk) disable iff (!por_n)
        (dbg_req_o && moe_o == 3'b101) |-> $past(ge_q && hm_q));

    p_rst_trap_r4: assert property (@(posedge clk) disable iff (!por_n)
        (dbg_req_o && moe_o == 3'b000) |-> $past(hm_q && trap0_q));

    p_sticky_set_r8: assert property (@(posedge clk) disable iff (!por_n)
        $past(dabort_i && sdbg_i && hm_q) |-> sticky_abort_o);

    p_sticky_hold_r8: assert property (@(posedge clk) disable iff (!por_n)
        ($past(sticky_abort_o) && !$past(sa_clr_wr)) |-> sticky_abort_o);

    p_moe_hold_r9: assert property (@(posedge clk) disable iff (!por_n)
        !dbg_req_o |-> $stable(moe_o));

endmodule

bind dbg_vtrap_ctrl dvt_checker u_chk (
    .clk            (clk),
    .por_n          (por_n),
    .core_rst_i     (core_rst_i),
    .sdbg_i         (sdbg_i),
    .dabort_i       (dabort_i),
    .hm_q           (hm_q),
    .ge_q           (ge_q),
    .trap0_q        (trap_q[0]),
    .sa_clr_wr      (sa_clr_wr),
    .dbg_req_o      (dbg_req_o),
    .moe_o          (moe_o),
    .sticky_abort_o (sticky_abort_o)
);

// File: tb/dbg_vtrap_ctrl_tb.sv
module dbg_vtrap_ctrl_tb;

    localparam int AW = 8;
    localparam int CW = 10;

    logic          clk = 1'b0;
    logic          por_n, core_rst, cfg_we;
    logic [CW-1:0] cfg_wdata;
    logic          fvalid;
    logic [AW-1:0] faddr;
    logic          ibrk, dbrk, swbrk, extbrk, tbfull, dabort, sdbg;
    logic          req;
    logic [2:0]    moe;
    logic          sticky;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    dbg_vtrap_ctrl #(.AW(AW)) u_dut (
        .clk            (clk),
        .por_n          (por_n),
        .core_rst_i     (core_rst),
        .cfg_we_i       (cfg_we),
        .cfg_wdata_i    (cfg_wdata),
        .fetch_valid_i  (fvalid),
        .fetch_addr_i   (faddr),
        .ibrk_i         (ibrk),
        .dbrk_i         (dbrk),
        .swbrk_i        (swbrk),
        .extbrk_i       (extbrk),
        .tbfull_i       (tbfull),
        .dabort_i       (dabort),
        .sdbg_i         (sdbg),
        .dbg_req_o      (req),
        .moe_o          (moe),
        .sticky_abort_o (sticky)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic cfg_write(input bit ge, input bit hm, input logic [6:0] trap, input bit clr);
        cfg_we    = 1'b1;
        cfg_wdata = {clr, trap, hm, ge};
        step();
        cfg_we    = 1'b0;
    endtask

    // Handler round trip: enter and leave special debug state.
    task automatic handler_rt();
        sdbg = 1'b1;
        step();
        sdbg = 1'b0;
        step();
        step();
    endtask

    // Vector index of an address, -1 if not a vector.
    function automatic int vec_of(input int a);
        if (a % 4 != 0) return -1;
        if (a / 4 <= 4) return a / 4;
        if (a == 'h18) return 5;
        if (a == 'h1C) return 6;
        return -1;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [6:0] masks [3];
        masks[0] = 7'h7F;
        masks[1] = 7'h55;
        masks[2] = 7'h2A;

        por_n = 1'b0; core_rst = 1'b1; cfg_we = 1'b0; cfg_wdata = '0;
        fvalid = 1'b0; faddr = '0; ibrk = 0; dbrk = 0; swbrk = 0;
        extbrk = 0; tbfull = 0; dabort = 0; sdbg = 0;
        step(); step();
        por_n = 1'b1;
        step();
        chk("R9 moe after por", moe, 0);
        chk("R1 req after por", req, 0);
        chk("R8 sticky after por", sticky, 0);

        // R4/R1: trap armed during reset, global enable clear
        cfg_write(1'b0, 1'b1, 7'h01, 1'b0);
        core_rst = 1'b0;
        step();
        chk("R4 no req first cycle", req, 0);
        step();
        chk("R4 reset trap req", req, 1);
        chk("R4 reset trap moe", moe, 0);
        step();
        chk("R6 pulse one cycle", req, 0);
        handler_rt();

        // R4: halt mode clear -> no reset trap
        cfg_write(1'b1, 1'b0, 7'h01, 1'b0);
        core_rst = 1'b1; step();
        core_rst = 1'b0; step();
        chk("R4 no trap hm=0 c1", req, 0);
        step();
        chk("R4 no trap hm=0 c2", req, 0);

        // R1: armed before reset, retained across it
        cfg_write(1'b0, 1'b1, 7'h01, 1'b0);
        core_rst = 1'b1; step(); step();
        core_rst = 1'b0; step();
        step();
        chk("R1 retained trap req", req, 1);
        chk("R1 retained trap moe", moe, 0);
        handler_rt();

        // R2/R3: full address sweep
        for (int gh = 0; gh < 4; gh++) begin
            for (int m = 0; m < 3; m++) begin
                cfg_write(gh[0], gh[1], masks[m], 1'b0);
                for (int a = 0; a < 256; a++) begin
                    int  k;
                    bit  e;
                    k = vec_of(a);
                    e = (k >= 1) && gh[0] && gh[1] && masks[m][k];
                    fvalid = 1'b1; faddr = AW'(a);
                    step();
                    fvalid = 1'b0;
                    if (k >= 1) chk("R2 vector trap req", req, int'(e));
                    else        chk("R3 non-vector no req", req, 0);
                    if (e) chk("R2 vector trap moe", moe, 5);
                    handler_rt();
                end
            end
        end

        // R2: vector address without fetch valid
        cfg_write(1'b1, 1'b1, 7'h7E, 1'b0);
        fvalid = 1'b0; faddr = 8'h08;
        step();
        chk("R2 no valid no req", req, 0);

        // R5: all cause combinations
        for (int c = 0; c < 64; c++) begin
            int exp_moe;
            fvalid = c[0]; faddr = 8'h08;
            ibrk = c[1]; dbrk = c[2]; swbrk = c[3]; extbrk = c[4]; tbfull = c[5];
            step();
            fvalid = 0; ibrk = 0; dbrk = 0; swbrk = 0; extbrk = 0; tbfull = 0;
            if (c[0])      exp_moe = 5;
            else if (c[1]) exp_moe = 1;
            else if (c[2]) exp_moe = 2;
            else if (c[3]) exp_moe = 3;
            else if (c[4]) exp_moe = 4;
            else           exp_moe = 6;
            chk("R5 req on any cause", req, int'(c != 0));
            if (c != 0) chk("R5 priority moe", moe, exp_moe);
            handler_rt();
        end

        // R6/R7: held cause is masked until a handler round trip
        ibrk = 1'b1;
        step();
        chk("R6 first req", req, 1);
        step();
        chk("R6 no repeat 1", req, 0);
        step();
        chk("R6 no repeat 2", req, 0);
        sdbg = 1'b1;
        step();
        chk("R7 masked in sds 1", req, 0);
        step();
        chk("R7 masked in sds 2", req, 0);
        sdbg = 1'b0;
        step();
        chk("R7 no req after sds", req, 0);
        step();
        chk("R6 req after round trip", req, 1);
        chk("R6 req moe ibrk", moe, 1);
        ibrk = 1'b0;
        handler_rt();
        step(); step();
        chk("R9 moe held", moe, 1);
        chk("R9 no spurious req", req, 0);

        // R7: core reset masks causes; R4 with global enable set
        cfg_write(1'b1, 1'b1, 7'h7F, 1'b0);
        core_rst = 1'b1; dbrk = 1'b1;
        step();
        chk("R7 masked in reset 1", req, 0);
        step();
        chk("R7 masked in reset 2", req, 0);
        core_rst = 1'b0; dbrk = 1'b0;
        step();
        chk("R4 ge=1 first cycle", req, 0);
        step();
        chk("R4 ge=1 reset trap", req, 1);
        chk("R4 ge=1 reset moe", moe, 0);
        handler_rt();

        // R8: sticky abort
        cfg_write(1'b0, 1'b1, 7'h00, 1'b0);
        sdbg = 1'b1; dabort = 1'b1;
        step();
        chk("R8 sticky set", sticky, 1);
        dabort = 1'b0;
        step(); step();
        chk("R8 sticky held", sticky, 1);
        sdbg = 1'b0;
        step();
        dabort = 1'b1;
        step();
        dabort = 1'b0;
        chk("R8 abort outside sds keeps", sticky, 1);
        cfg_write(1'b0, 1'b1, 7'h00, 1'b1);
        chk("R8 sticky cleared", sticky, 0);
        step();
        dabort = 1'b1;
        step();
        dabort = 1'b0;
        chk("R8 abort outside sds no set", sticky, 0);
        cfg_write(1'b0, 1'b0, 7'h00, 1'b0);
        sdbg = 1'b1; dabort = 1'b1;
        step();
        chk("R8 no set without halt", sticky, 0);
        dabort = 1'b0;
        cfg_write(1'b0, 1'b1, 7'h00, 1'b0);
        dabort = 1'b1;
        cfg_we = 1'b1; cfg_wdata = {1'b1, 7'h00, 1'b1, 1'b0};
        step();
        cfg_we = 1'b0; dabort = 1'b0;
        chk("R8 set wins over clear", sticky, 1);
        sdbg = 1'b0;
        step(); step();
        chk("R8 no req from abort", req, 0);

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule